// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two timer/counter units, each made of an 8-bit low byte and an 8-bit high byte. One 8-bit configuration register picks, for each unit, an operating mode, whether the unit counts internal machine-cycle ticks or events on an external count pin, and whether an external gate pin qualifies counting. The four modes are:

- a 13-bit count, with a 5-bit prescaler in the low byte;
- a full 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split mode that turns unit 0 into two independent 8-bit counters.

Each unit has a sticky overflow flag. The flags are also driven out as pins.

Software reaches the configuration byte, the control byte (run and flag bits) and the four count bytes through a simple register port. Writes are synchronous and reads are combinational. The `tick` input marks machine cycles, and nothing counts on a clock edge without it. The count pins are sampled on ticks, and a 1-to-0 change between two consecutive samples counts as one event.

Top module: `dual_tc`

## Requirements
- R1: After reset every register reads zero, both units are stopped and both `ovf` outputs are low. Addresses 6 and 7 always read zero.
- R2: The register map is as follows.
  - Address 0 is the configuration byte. Bits 3..0 set up unit 0 and bits 7..4 set up unit 1. Within each nibble, the top bit is gate enable, the next bit is external-count select, and the low two bits are the mode.
  - Address 1 is the control byte: bit0 is run0, bit1 is run1, bit2 is flag0 and bit3 is flag1.
  - Addresses 2 and 3 are the unit 0 low and high bytes. Addresses 4 and 5 are the unit 1 low and high bytes.
  - A software write to a count byte takes precedence over counting in the same cycle.
- R3: With external-count select 0, a running unit advances by one on each cycle where `tick` is high, and holds when `tick` is low.
- R4: With external-count select 1, the count pin is sampled on each tick. The unit advances on the tick that follows the tick whose sample is 0 when the previous sample was 1.
- R5: With gate enable 1, a unit advances only on ticks where its `gate_pin` is high and its run bit is set.
- R6: In mode 0, the low 5 bits of the low byte act as a prescaler under the high byte, forming a 13-bit count. Bits 7..5 of the low byte are left unchanged. The flag sets when the 13-bit value wraps from all ones to zero.
- R7: In mode 1, the high and low bytes form a 16-bit count, and the flag sets on the wrap from 0xFFFF to 0.
- R8: In mode 2, the low byte counts. When it is incremented from 0xFF, it loads the high byte's value and sets the flag. The high byte never changes by counting.
- R9: In mode 3, unit 0's low byte is an 8-bit counter that uses unit 0's gate, select and run bits, and it sets flag0 when it wraps.
- R10: In mode 3, unit 0's high byte is an 8-bit timer that advances on every tick while run1 is set. It ignores gate and pins, and its wrap sets flag1. While unit 0 is in mode 3, wraps of unit 1 do not set flag1.
- R11: Unit 1 in mode 3 holds its count.
- R12: A flag stays set until software writes 0 to it. If a flag is set and cleared by software in the same cycle, it ends up set.
- R13: `ovf[0]` and `ovf[1]` show flag0 and flag1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | External gate inputs, one per unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ovf | output | 2 | Overflow flags of unit 0 and unit 1 |

## Verification
The bench goes after each wrap boundary:
- In mode 0, a prescaler that carried on its own wrap at 0x1F would corrupt bits 7..5 of the low byte. A full 8-bit carry would advance the high byte 8 times too slowly.
- A mode 2 reload that cleared the low byte, or that touched the high byte, would be caught on the first wrap.

The pin edge timing is probed next. A design that counted on the sampling tick itself would lead by one tick, and one that triggered on rising edges would count at the wrong time.

The split mode is checked for flag1 sourcing. A design that let unit 1's wraps through would raise flag1 spuriously. A design that started unit 0's high byte with run0 would leave it frozen.

A flag clear that beats a simultaneous set would lose an overflow, and the random phase aims writes at near-wrap values to create that collision.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MD_PRESC  = 2'd0,
        MD_WIDE   = 2'd1,
        MD_RELOAD = 2'd2,
        MD_SPLIT  = 2'd3
    } tc_mode_e;

    typedef struct packed {
        logic     gate;
        logic     ext;
        tc_mode_e md;
    } tc_cfg_t;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;
endpackage

// File: rtl/dtc_sampler.sv
`timescale 1ns/1ps
module dtc_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.prev = s_q.cur;
            s_d.cur  = pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // pending event: last two samples were 1 then 0; consumed on the next tick
    assign fall = s_q.prev & ~s_q.cur;
endmodule

// File: rtl/dtc_unit.sv
`timescale 1ns/1ps
module dtc_unit
    import dtc_pkg::*;
#(
    parameter int BW       = 8,
    parameter int PRE_W    = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  tc_mode_e      md,
    input  logic          inc,
    input  logic          inc_hi,
    input  logic [BW-1:0] lo,
    input  logic [BW-1:0] hi,
    output logic [BW-1:0] lo_n,
    output logic [BW-1:0] hi_n,
    output logic          wrap,
    output logic          wrap_hi
);
    localparam int PW = BW + PRE_W;
    localparam int WW = 2 * BW;

    logic [PW:0] pre_sum;
    logic [WW:0] wide_sum;
    logic [BW:0] lo_sum;
    logic [BW:0] hi_sum;

    always_comb begin
        pre_sum  = {1'b0, hi, lo[PRE_W-1:0]} + 1'b1;
        wide_sum = {1'b0, hi, lo} + 1'b1;
        lo_sum   = {1'b0, lo} + 1'b1;
        hi_sum   = {1'b0, hi} + 1'b1;
        lo_n     = lo;
        hi_n     = hi;
        wrap     = 1'b0;
        wrap_hi  = 1'b0;
        case (md)
            MD_PRESC: if (inc) begin
                lo_n[PRE_W-1:0] = pre_sum[PRE_W-1:0];
                hi_n            = pre_sum[PW-1:PRE_W];
                wrap            = pre_sum[PW];
            end
            MD_WIDE: if (inc) begin
                {hi_n, lo_n} = wide_sum[WW-1:0];
                wrap         = wide_sum[WW];
            end
            MD_RELOAD: if (inc) begin
                if (lo_sum[BW]) begin
                    lo_n = hi;
                    wrap = 1'b1;
                end else begin
                    lo_n = lo_sum[BW-1:0];
                end
            end
            default: begin
                if (SPLIT_OK) begin
                    if (inc) begin
                        lo_n = lo_sum[BW-1:0];
                        wrap = lo_sum[BW];
                    end
                    if (inc_hi) begin
                        hi_n    = hi_sum[BW-1:0];
                        wrap_hi = hi_sum[BW];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/dual_tc.sv
`timescale 1ns/1ps
module dual_tc
    import dtc_pkg::*;
#(
    parameter int PRE_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          cnt_pin,
    input  logic [1:0]          gate_pin,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [1:0]          ovf
);
    localparam int N_UNIT = 2;
    localparam int NIB    = BYTE_W / N_UNIT;

    typedef struct packed {
        logic [BYTE_W-1:0]             cfg;
        logic [N_UNIT-1:0]             run;
        logic [N_UNIT-1:0]             flag;
        logic [N_UNIT-1:0][BYTE_W-1:0] lo;
        logic [N_UNIT-1:0][BYTE_W-1:0] hi;
    } st_t;

    st_t st_d, st_q;

    tc_cfg_t [N_UNIT-1:0]             ucfg;
    logic    [N_UNIT-1:0]             fall;
    logic    [N_UNIT-1:0]             inc;
    logic    [N_UNIT-1:0]             inc_hi;
    logic    [N_UNIT-1:0]             wrap;
    logic    [N_UNIT-1:0]             wrap_hi;
    logic    [N_UNIT-1:0][BYTE_W-1:0] lo_n;
    logic    [N_UNIT-1:0][BYTE_W-1:0] hi_n;
    logic    [N_UNIT-1:0]             flag_set;
    logic                             split0;

    dtc_sampler #(.N(N_UNIT)) u_smp (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .pin  (cnt_pin),
        .fall (fall)
    );

    assign split0 = (ucfg[0].md == MD_SPLIT);

    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
        assign ucfg[u] = tc_cfg_t'(st_q.cfg[u*NIB +: NIB]);
        assign inc[u]  = tick & st_q.run[u]
                       & (~ucfg[u].gate | gate_pin[u])
                       & (~ucfg[u].ext  | fall[u]);
        if (u == 0) begin : g_hi_src
            // split-mode high byte: timer only, started by unit 1's run bit
            assign inc_hi[u] = tick & st_q.run[1];
        end else begin : g_hi_off
            assign inc_hi[u] = 1'b0;
        end
        dtc_unit #(
            .BW      (BYTE_W),
            .PRE_W   (PRE_W),
            .SPLIT_OK(u == 0)
        ) u_cnt (
            .md     (ucfg[u].md),
            .inc    (inc[u]),
            .inc_hi (inc_hi[u]),
            .lo     (st_q.lo[u]),
            .hi     (st_q.hi[u]),
            .lo_n   (lo_n[u]),
            .hi_n   (hi_n[u]),
            .wrap   (wrap[u]),
            .wrap_hi(wrap_hi[u])
        );
    end

    assign flag_set[0] = wrap[0];
    assign flag_set[1] = split0 ? wrap_hi[0] : (wrap[1] | wrap_hi[1]);

    always_comb begin
        st_d    = st_q;
        st_d.lo = lo_n;
        st_d.hi = hi_n;
        if (wr_en) begin
            case (wr_addr)
                A_CFG:  st_d.cfg = wr_data;
                A_CTRL: begin
                    st_d.run  = wr_data[1:0];
                    st_d.flag = wr_data[3:2];
                end
                A_LO0:  st_d.lo[0] = wr_data;
                A_HI0:  st_d.hi[0] = wr_data;
                A_LO1:  st_d.lo[1] = wr_data;
                A_HI1:  st_d.hi[1] = wr_data;
                default: ;
            endcase
        end
        st_d.flag = st_d.flag | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr)
            A_CFG:   rd_data = st_q.cfg;
            A_CTRL:  rd_data = {{(BYTE_W-4){1'b0}}, st_q.flag, st_q.run};
            A_LO0:   rd_data = st_q.lo[0];
            A_HI0:   rd_data = st_q.hi[0];
            A_LO1:   rd_data = st_q.lo[1];
            A_HI1:   rd_data = st_q.hi[1];
            default: rd_data = '0;
        endcase
    end

    assign ovf = st_q.flag;
endmodule

// File: rtl/dual_tc_chk.sv
`timescale 1ns/1ps
module dual_tc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] cfg,
    input logic [1:0] ovf,
    input logic [1:0] flag_set,
    input logic [7:0] lo0,
    input logic [7:0] hi0,
    input logic [7:0] lo1,
    input logic [7:0] hi1
);
    AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[0] && !(wr_en && wr_addr == 3'd1)) |=> ovf[0]); // R12

    AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[1] && !(wr_en && wr_addr == 3'd1)) |=> ovf[1]); // R12

    AST_SET_BEATS_CLEAR0: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[0] |=> ovf[0]); // R12

    AST_SET_BEATS_CLEAR1: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[1] |=> ovf[1]); // R12

    AST_UNIT1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[5:4] == 2'b11 && !(wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5)))
        |=> ($stable(lo1) && $stable(hi1))); // R11

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en)
        |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1))); // R3

    AST_RELOAD_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1:0] == 2'b10 && !(wr_en && wr_addr == 3'd3)) |=> $stable(hi0)); // R8
endmodule

bind dual_tc dual_tc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cfg     (st_q.cfg),
    .ovf     (ovf),
    .flag_set(flag_set),
    .lo0     (st_q.lo[0]),
    .hi0     (st_q.hi[0]),
    .lo1     (st_q.lo[1]),
    .hi1     (st_q.hi[1])
);

// File: tb/dual_tc_bench.sv
`timescale 1ns/1ps
module dual_tc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state, built from the requirements
    logic [7:0] m_cfg = '0;
    logic [1:0] m_run = '0;
    logic [1:0] m_flag = '0;
    logic [7:0] m_lo [2] = '{8'h00, 8'h00};
    logic [7:0] m_hi [2] = '{8'h00, 8'h00};
    logic [1:0] m_cur = '0;
    logic [1:0] m_prev = '0;

    dual_tc u_dual_tc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ovf(ovf)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic model(input bit tk, input logic [1:0] cp, input logic [1:0] gp,
                         input bit we, input logic [2:0] wa, input logic [7:0] wd);
        logic [1:0] fl;
        logic [1:0] setf;
        logic [7:0] nlo [2];
        logic [7:0] nhi [2];
        int v;
        fl = m_prev & ~m_cur;
        setf = '0;
        nlo = m_lo;
        nhi = m_hi;
        if (tk) begin
            for (int u = 0; u < 2; u++) begin
                logic [1:0] md;
                bit inc;
                bit wr;
                md  = m_cfg[4*u +: 2];
                inc = m_run[u] && (!m_cfg[4*u+3] || gp[u]) && (!m_cfg[4*u+2] || fl[u]);
                wr  = 1'b0;
                if (inc) begin
                    case (md)
                        2'd0: begin
                            v = int'(m_hi[u]) * 32 + int'(m_lo[u] & 8'h1F) + 1;
                            if (v == 8192) begin v = 0; wr = 1'b1; end
                            nlo[u] = (m_lo[u] & 8'hE0) | 8'(v % 32);
                            nhi[u] = 8'(v / 32);
                        end
                        2'd1: begin
                            v = int'(m_hi[u]) * 256 + int'(m_lo[u]) + 1;
                            if (v == 65536) begin v = 0; wr = 1'b1; end
                            nlo[u] = 8'(v % 256);
                            nhi[u] = 8'(v / 256);
                        end
                        2'd2: begin
                            if (m_lo[u] == 8'hFF) begin nlo[u] = m_hi[u]; wr = 1'b1; end
                            else nlo[u] = m_lo[u] + 8'd1;
                        end
                        default: begin
                            if (u == 0) begin
                                if (m_lo[0] == 8'hFF) wr = 1'b1;
                                nlo[0] = m_lo[0] + 8'd1;
                            end
                        end
                    endcase
                end
                if (wr && (u == 0 || m_cfg[1:0] != 2'd3)) setf[u] = 1'b1;
            end
            if (m_cfg[1:0] == 2'd3 && m_run[1]) begin
                if (m_hi[0] == 8'hFF) setf[1] = 1'b1;
                nhi[0] = m_hi[0] + 8'd1;
            end
            m_prev = m_cur;
            m_cur  = cp;
        end
        if (we) begin
            case (wa)
                3'd0: m_cfg = wd;
                3'd1: begin m_run = wd[1:0]; m_flag = wd[3:2]; end
                3'd2: nlo[0] = wd;
                3'd3: nhi[0] = wd;
                3'd4: nlo[1] = wd;
                3'd5: nhi[1] = wd;
                default: ;
            endcase
        end
        m_flag = m_flag | setf;
        m_lo = nlo;
        m_hi = nhi;
    endtask

    task automatic step(input bit tk, input logic [1:0] cp, input logic [1:0] gp,
                        input bit we, input logic [2:0] wa, input logic [7:0] wd);
        @(negedge clk);
        tick = tk; cnt_pin = cp; gate_pin = gp;
        wr_en = we; wr_addr = wa; wr_data = wd;
        model(tk, cp, gp, we, wa, wd);
        @(posedge clk);
        #0.5;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        step(1'b0, cnt_pin, gate_pin, 1'b1, a, d);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        rd(3'd0, v); chk({tag, " cfg"},  v, m_cfg);
        rd(3'd1, v); chk({tag, " ctrl"}, v, {4'h0, m_flag, m_run});
        rd(3'd2, v); chk({tag, " lo0"},  v, m_lo[0]);
        rd(3'd3, v); chk({tag, " hi0"},  v, m_hi[0]);
        rd(3'd4, v); chk({tag, " lo1"},  v, m_lo[1]);
        rd(3'd5, v); chk({tag, " hi1"},  v, m_hi[1]);
        chk({tag, " R13 ovf"}, ovf, m_flag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #0.5;

        // R1: reset state and unmapped addresses
        check_all("R1");
        rd(3'd6, v); chk("R1 addr6", v, 0);
        rd(3'd7, v); chk("R1 addr7", v, 0);

        // R7: 16-bit wrap sets flag0
        wreg(3'd0, 8'h01); wreg(3'd2, 8'hFE); wreg(3'd3, 8'hFF); wreg(3'd1, 8'h01);
        step(1, 0, 0, 0, 0, 0);
        rd(3'd2, v); chk("R7 lo0 at FFFF", v, 8'hFF);
        step(1, 0, 0, 0, 0, 0);
        rd(3'd2, v); chk("R7 lo0 wrapped", v, 0);
        rd(3'd3, v); chk("R7 hi0 wrapped", v, 0);
        chk("R7 flag0", ovf[0], 1);

        // R12: clear and set in the same cycle -> set wins; plain clear works
        wreg(3'd2, 8'hFF); wreg(3'd3, 8'hFF);
        step(1, 0, 0, 1, 3'd1, 8'h01);
        chk("R12 set beats clear", ovf[0], 1);
        wreg(3'd1, 8'h00);
        chk("R12 clear", ovf[0], 0);

        // R3: no tick, no motion
        wreg(3'd2, 8'h10); wreg(3'd1, 8'h01);
        step(0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
        rd(3'd2, v); chk("R3 idle", v, 8'h10);
        step(1, 0, 0, 0, 0, 0);
        rd(3'd2, v); chk("R3 tick", v, 8'h11);

        // R6: prescaler carry keeps bits 7..5
        wreg(3'd1, 8'h00); wreg(3'd0, 8'h00);
        wreg(3'd2, 8'hBF); wreg(3'd3, 8'h12); wreg(3'd1, 8'h01);
        step(1, 0, 0, 0, 0, 0);
        rd(3'd2, v); chk("R6 lo0 keeps top bits", v, 8'hA0);
        rd(3'd3, v); chk("R6 hi0 carry", v, 8'h13);
        wreg(3'd2, 8'hFF); wreg(3'd3, 8'hFF);
        step(1, 0, 0, 0, 0, 0);
        chk("R6 13-bit wrap flag", ovf[0], 1);
        rd(3'd2, v); chk("R6 lo0 after wrap", v, 8'hE0);

        // R8: reload from high byte
        wreg(3'd1, 8'h00); wreg(3'd0, 8'h02);
        wreg(3'd3, 8'h80); wreg(3'd2, 8'hFF); wreg(3'd1, 8'h01);
        step(1, 0, 0, 0, 0, 0);
        rd(3'd2, v); chk("R8 reload value", v, 8'h80);
        rd(3'd3, v); chk("R8 high unchanged", v, 8'h80);
        chk("R8 flag0", ovf[0], 1);

        // R4: falling edge timing on the count pin
        wreg(3'd1, 8'h00); wreg(3'd0, 8'h05); wreg(3'd2, 8'h00); wreg(3'd3, 8'h00);
        wreg(3'd1, 8'h01);
        step(1, 2'b01, 0, 0, 0, 0);
        step(1, 2'b00, 0, 0, 0, 0);
        rd(3'd2, v); chk("R4 not yet", v, 0);
        step(1, 2'b00, 0, 0, 0, 0);
        rd(3'd2, v); chk("R4 counted", v, 1);
        step(1, 2'b01, 0, 0, 0, 0);
        step(1, 2'b01, 0, 0, 0, 0);
        rd(3'd2, v); chk("R4 rise ignored", v, 1);

        // R5: gating
        wreg(3'd0, 8'h09);
        step(1, 0, 2'b00, 0, 0, 0); step(1, 0, 2'b00, 0, 0, 0);
        rd(3'd2, v); chk("R5 gate low", v, 1);
        step(1, 0, 2'b01, 0, 0, 0);
        rd(3'd2, v); chk("R5 gate high", v, 2);

        // R10: split high byte run by run1, sets flag1
        wreg(3'd1, 8'h00); wreg(3'd0, 8'h03); wreg(3'd3, 8'hFF); wreg(3'd2, 8'h40);
        wreg(3'd1, 8'h02);
        step(1, 0, 0, 0, 0, 0);
        rd(3'd3, v); chk("R10 hi0 wrap", v, 0);
        rd(3'd2, v); chk("R9 lo0 stopped", v, 8'h40);
        chk("R10 flag1", ovf[1], 1);
        // R9: low byte with run0
        wreg(3'd1, 8'h01); wreg(3'd2, 8'hFF);
        step(1, 0, 0, 0, 0, 0);
        chk("R9 flag0", ovf[0], 1);
        rd(3'd3, v); chk("R10 hi0 needs run1", v, 0);

        // R10: unit 1 wraps suppressed while unit 0 split
        wreg(3'd1, 8'h00); wreg(3'd0, 8'h13); wreg(3'd3, 8'h00);
        wreg(3'd4, 8'hFF); wreg(3'd5, 8'hFF); wreg(3'd1, 8'h02);
        step(1, 0, 0, 0, 0, 0);
        rd(3'd4, v); chk("R10 unit1 wrapped", v, 0);
        chk("R10 flag1 suppressed", ovf[1], 0);

        // R11: unit 1 in mode 3 holds
        wreg(3'd0, 8'h30); wreg(3'd4, 8'h55);
        step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
        rd(3'd4, v); chk("R11 hold", v, 8'h55);

        // R2: write beats counting in the same cycle
        wreg(3'd0, 8'h01); wreg(3'd1, 8'h01);
        step(1, 0, 0, 1, 3'd2, 8'h33);
        rd(3'd2, v); chk("R2 write wins", v, 8'h33);
        check_all("R2 directed");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit we;
            logic [2:0] wa;
            logic [7:0] wd;
            we = ($urandom % 12) == 0;
            wa = 3'($urandom % 8);
            wd = (($urandom % 3) == 0) ? 8'($urandom) : (8'hF8 | 8'($urandom % 8));
            if (we && wa == 3'd1 && ($urandom % 2) == 1) wd[1:0] = 2'b11;
            step(($urandom % 5) != 0, 2'($urandom), 2'($urandom), we, wa, wd);
            if (i % 4 == 0) check_all("R3-rand");
            else chk("R12 rand ovf", ovf, m_flag);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule